// File: doc/BRIEF.md
# Double-Buffered Serial DAC Input Interface

This block is the digital front end of a serial-loaded digital-to-analog converter. A host drives three serial wires: a data line, a serial clock and a load line. It also drives an active-low clear. Bits enter an input shift register most significant bit first. A separate holding register keeps the converter code stable, so the host can preload the next word while the present code stays on the output.

All four pins are asynchronous to the fast system clock. Each passes through a two-flop synchroniser. Registered edge detectors then turn the serial clock rising edge and the load falling edge into single-cycle events, so every action is synchronous to the system clock.

A small control state machine owns the holding register. Its states are:
- `ST_CLEAR`: clear is held low and the code is forced to zero.
- `ST_ARMED`: load is high and shifting is enabled.
- `ST_LOCKED`: load is low and serial clocks are ignored.

Its transitions are:
- Any state moves to `ST_CLEAR` while clear is low.
- `ST_CLEAR` moves to `ST_LOCKED` on clear release with load low. This transition also copies the shift register into the holding register.
- `ST_CLEAR` moves to `ST_ARMED` on clear release with load high. The code stays at zero.
- `ST_ARMED` moves to `ST_LOCKED` on a load falling edge. This transition copies the shift register into the holding register.
- `ST_LOCKED` moves to `ST_ARMED` when load goes high again.

Top module: `dacfe_front`

## Requirements
- R1: On each rising edge of the synchronised serial clock while load is high, the shift register moves up one place and takes the data bit in its least significant position. Bits therefore enter most significant bit first.
- R2: The shift register is exactly `CODE_W` bits wide (12 by default, 10 in the reduced variant). If a frame is longer, only the last `CODE_W` bits shifted in are kept. If a frame is shorter, the bits from earlier frames remain above the new bits.
- R3: Serial clock edges that arrive while load is low do not change the shift register.
- R4: A high-to-low transition of load copies the shift register into the holding register, which drives `code`.
- R5: Shifting alone never changes `code`.
- R6: While clear is low, `code` is zero regardless of load activity.
- R7: If load is low when clear returns high, `code` takes the shift register contents at once.
- R8: If load is high when clear returns high, `code` stays zero until the next load falling edge.
- R9: Clear leaves the shift register contents intact.
- R10: An active-high system reset sets both the shift register and `code` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial data, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous; sampled on its rising edge |
| load | input | 1 | Load line; its falling edge transfers the word |
| clr_n | input | 1 | Active-low clear of the holding register |
| code | output | CODE_W | Converter code from the holding register |

## Verification
The assertions work on the synchronised pin copies. They assume that each pin level is held for at least two system clocks, so that no edge is lost inside the synchroniser. They also assume that data is stable around each serial clock rise. The bench meets this by holding every pin level for four system clocks. It changes data only while the serial clock is low, and it moves load and clear only when the serial clock is idle.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR  = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LOCKED = 2'd2
    } ctrl_state_t;

    localparam int PIN_CNT = 4;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int          N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dacfe_edge.sv
module dacfe_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/dacfe_shift.sv
module dacfe_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)     word <= '0;
        else if (en) word <= {word[W-2:0], bit_in};
    end
endmodule

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
    import dacfe_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_s,
    input  logic         ld_s,
    input  logic         ld_fall,
    input  logic [W-1:0] shift_word,
    output logic [W-1:0] code
);
    ctrl_state_t state_q, state_d;
    logic [W-1:0] code_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_CLEAR;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!clr_s) begin
            state_d = ST_CLEAR;
        end else begin
            unique case (state_q)
                ST_CLEAR:  state_d = ld_s ? ST_ARMED : ST_LOCKED;
                ST_ARMED:  state_d = ld_fall ? ST_LOCKED : ST_ARMED;
                ST_LOCKED: state_d = ld_s ? ST_ARMED : ST_LOCKED;
                default:   state_d = ST_CLEAR;
            endcase
        end
    end

    always_comb begin
        code_d = code;
        if (!clr_s) begin
            code_d = '0;
        end else begin
            unique case (state_q)
                ST_CLEAR:  code_d = ld_s ? '0 : shift_word;
                ST_ARMED:  code_d = ld_fall ? shift_word : code;
                ST_LOCKED: code_d = code;
                default:   code_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) code <= '0;
        else     code <= code_d;
    end
endmodule

// File: rtl/dacfe_front.sv
module dacfe_front
    import dacfe_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdi,
    input  logic              sclk,
    input  logic              load,
    input  logic              clr_n,
    output logic [CODE_W-1:0] code
);
    localparam logic [PIN_CNT-1:0] PIN_RST = 4'b0010;

    logic [PIN_CNT-1:0] pins_s;
    logic sdi_s, sclk_s, ld_s, clr_s;
    logic sclk_rise, sclk_fall_unused;
    logic ld_rise_unused, ld_fall;
    logic shift_en;
    logic [CODE_W-1:0] shift_word;

    dacfe_sync #(.N(PIN_CNT), .RST_VAL(PIN_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sdi, sclk, load, clr_n}),
        .q   (pins_s)
    );

    assign sdi_s  = pins_s[3];
    assign sclk_s = pins_s[2];
    assign ld_s   = pins_s[1];
    assign clr_s  = pins_s[0];

    dacfe_edge #(.RST_VAL(1'b0)) u_sclk_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sclk_s),
        .rise (sclk_rise),
        .fall (sclk_fall_unused)
    );

    dacfe_edge #(.RST_VAL(1'b1)) u_ld_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ld_s),
        .rise (ld_rise_unused),
        .fall (ld_fall)
    );

    assign shift_en = sclk_rise & ld_s;

    dacfe_shift #(.W(CODE_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .en     (shift_en),
        .bit_in (sdi_s),
        .word   (shift_word)
    );

    dacfe_ctrl #(.W(CODE_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .clr_s      (clr_s),
        .ld_s       (ld_s),
        .ld_fall    (ld_fall),
        .shift_word (shift_word),
        .code       (code)
    );
endmodule

// File: rtl/dacfe_front_chk.sv
module dacfe_front_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         clr_s,
    input logic         ld_s,
    input logic         ld_fall,
    input logic         sclk_rise,
    input logic         sdi_s,
    input logic [W-1:0] shift_word,
    input logic [W-1:0] code
);
    AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise && ld_s) |=> shift_word == {$past(shift_word[W-2:0]), $past(sdi_s)}); // R1

    AST_LOCKED_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        !ld_s |=> $stable(shift_word)); // R3

    AST_FALL_TRANSFER: assert property (@(posedge clk) disable iff (rst)
        (ld_fall && clr_s) |=> code == $past(shift_word)); // R4

    AST_HOLD_WHILE_ARMED: assert property (@(posedge clk) disable iff (rst)
        (ld_s && clr_s && $past(ld_s) && $past(clr_s)) |=> $stable(code)); // R5

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        !clr_s |=> code == '0); // R6

    AST_RELEASE_LOW_LOADS: assert property (@(posedge clk) disable iff (rst)
        ($rose(clr_s) && !ld_s) |=> code == $past(shift_word)); // R7

    AST_RELEASE_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($rose(clr_s) && ld_s) |=> code == '0); // R8
endmodule

bind dacfe_front dacfe_front_chk #(.W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_s      (clr_s),
    .ld_s       (ld_s),
    .ld_fall    (ld_fall),
    .sclk_rise  (sclk_rise),
    .sdi_s      (sdi_s),
    .shift_word (shift_word),
    .code       (code)
);

// File: tb/sim_dacfe_front.sv
module sim_dacfe_front;
    localparam int W  = 12;
    localparam int NV = 7;
    localparam logic [15:0] VEC_FRAME [NV] = '{16'hABCD, 16'h05A3, 16'h0FFF, 16'h00C3,
                                                16'h8001, 16'h0FFF, 16'h0000};
    localparam int          VEC_BITS  [NV] = '{16, 12, 16, 8, 16, 12, 12};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sdi = 1'b0, sclk = 1'b0, load = 1'b1, clr_n = 1'b1;
    logic [W-1:0] code;
    logic [W-1:0] model_sr = '0;
    logic [W-1:0] model_code = '0;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dacfe_front #(.CODE_W(W)) u0 (
        .clk(clk), .rst(rst), .sdi(sdi), .sclk(sclk),
        .load(load), .clr_n(clr_n), .code(code)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] exp_v);
        @(negedge clk);
        checks++;
        if (code !== exp_v) begin
            errors++;
            $display("FAIL %s code=%h expected=%h", req, code, exp_v);
        end
    endtask

    task automatic send_bit(input logic b, input bit model_on);
        sdi = b;       wait_clk(4);
        sclk = 1'b1;   wait_clk(4);
        sclk = 1'b0;   wait_clk(4);
        if (model_on) model_sr = {model_sr[W-2:0], b};
    endtask

    task automatic send_frame(input logic [15:0] fr, input int nb, input bit model_on);
        for (int i = nb - 1; i >= 0; i--) send_bit(fr[i], model_on);
    endtask

    task automatic set_load(input logic v);
        load = v; wait_clk(6);
    endtask

    task automatic set_clr(input logic v);
        clr_n = v; wait_clk(6);
    endtask

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(6);
        check("R10 reset code", '0);

        for (int v = 0; v < NV; v++) begin
            send_frame(VEC_FRAME[v], VEC_BITS[v], 1'b1);
            check("R5 hold during shift", model_code);
            set_load(1'b0);
            model_code = model_sr;
            check("R1 R2 transfer on load fall", model_code);
            set_load(1'b1);
        end

        set_load(1'b0);
        send_frame(16'h0ABC, 12, 1'b0);
        set_load(1'b1);
        set_load(1'b0);
        check("R3 clocks ignored while load low", model_sr);
        model_code = model_sr;
        set_load(1'b1);

        send_frame(16'h0123, 12, 1'b1);
        set_load(1'b0);
        model_code = model_sr;
        check("R4 load fall transfer", model_code);

        set_clr(1'b0);
        check("R6 clear forces zero", '0);
        set_load(1'b1);
        set_load(1'b0);
        check("R6 clear overrides load fall", '0);

        set_clr(1'b1);
        check("R7 R9 release with load low", model_sr);

        set_load(1'b1);
        set_clr(1'b0);
        set_clr(1'b1);
        check("R8 release with load high", '0);
        set_load(1'b0);
        check("R9 shift kept through clear", model_sr);

        set_load(1'b1);
        send_frame(16'h0F0F, 12, 1'b1);
        rst = 1'b1; wait_clk(3); rst = 1'b0; wait_clk(6);
        check("R10 reset clears code", '0);
        set_load(1'b0);
        check("R10 reset clears shift register", '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog code=%h expected=completion", code);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule